// File: doc/BRIEF.md
# Block Process Call Read Responder

This block produces the read-side replies of an I2C target test device for two test commands: a block process call and a version-string query. The front end decodes a write message and hands the command code and its two parameter bytes to the responder in a single strobe. The responder then follows the target's event stream (repeated start, start, stop), and supplies one reply byte at a time as the read transfer requests them.

A block process call reply is a length byte N followed by a countdown N-1 … 0. A version query reply is a NUL-terminated string that begins with `v`. Either reply is given only when the read follows the write through a repeated start. If a stop and then a fresh start separate the write from the read, the responder serves the default byte 0x00 instead. A stop that ends the read returns the block to idle and pulses `donePulse` to the front end. While a command is in progress, any new command is refused.

Top module: `blkcall_responder`

## Requirements
- R1: After reset, `busy`, `donePulse`, `rejectPulse` and `repEntry` are 0 and `rdData` is 0x00.
- R2: Command code 0x03 is accepted only when `paramLo` equals 0x01, and `busy` is 1 on the cycle after the strobe. With any other `paramLo`, `rejectPulse` is 1 on the cycle after the strobe and `busy` stays 0.
- R3: Any command code other than 0x03 or 0x04 is refused with `rejectPulse` and leaves `busy` at 0.
- R4: For an accepted 0x03 command with `paramHi` = N, a read entered by repeated start returns N first, then N-1, N-2 and so on down to 0x00. For N = 0x10 that is 17 bytes.
- R5: Once the last counted byte has been read, every further read request returns 0x00. This includes N = 0, which returns 0x00 and then only 0x00.
- R6: For command 0x04 with a repeated-start read, the reply is the version string "v2.7.1" (0x76 0x32 0x2E 0x37 0x2E 0x31), followed by a NUL byte, and then 0x00 for every later request.
- R7: If a stop and then a new start come between the accepted command and the read, every read byte is 0x00, whatever the command was.
- R8: A stop during the read transfer makes `donePulse` 1 for exactly one cycle, on the cycle after the stop, with `busy` 0 in that same cycle.
- R9: A command strobe while `busy` is 1 is refused with `rejectPulse`, and the reply already in progress continues unchanged.
- R10: `repEntry` is 1 while a read entered through a repeated start is being served, and 0 in the default (stop-then-start) read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | One-cycle strobe: decoded command available |
| cmdCode | input | 8 | Command code (0x03 block call, 0x04 version) |
| paramLo | input | 8 | First parameter byte (must be 0x01 for 0x03) |
| paramHi | input | 8 | Second parameter byte (count N for 0x03) |
| evRepStart | input | 1 | Repeated start seen on the bus |
| evStart | input | 1 | Start after a stop seen on the bus |
| evStop | input | 1 | Stop seen on the bus |
| rdReq | input | 1 | Current `rdData` byte is taken; advance |
| rdData | output | 8 | Byte to transmit on the next read request |
| repEntry | output | 1 | Serving a repeated-start read |
| busy | output | 1 | Command in progress |
| donePulse | output | 1 | Read transfer finished |
| rejectPulse | output | 1 | Command refused |

## Verification
The hardest situation to reach is a read entered through a stop followed by a new start after a valid command has been accepted. That read must return the default byte even though the reply state is already loaded. A second hard corner is a read that runs past the end of the counted bytes or past the string terminator. The stimulus reaches both through a vector table. Each row selects the entry path (repeated start, or stop then start) and asks for more reads than the reply length, so the countdown, the NUL and the zero tail are all seen for each command. Directed sequences then inject a second command during a live read and confirm that the countdown continues unchanged.

// File: rtl/blkcall_pkg.sv
package blkcall_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ARMED, S_AFTERSTOP, S_SERVE, S_DEFAULT
  } ctlState_t;

  typedef enum logic {
    M_COUNT, M_VERSION
  } respMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic      load;
    respMode_t mode;
    logic      clear;
    logic      advance;
  } dpStrobe_t;

  localparam logic [7:0] CODE_BLKCALL = 8'h03;
  localparam logic [7:0] CODE_VERSION = 8'h04;
endpackage

// File: rtl/blkcall_ctrl.sv
module blkcall_ctrl
  import blkcall_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [7:0] cmdCode,
  input  logic [7:0] paramLo,
  input  logic       evRepStart,
  input  logic       evStart,
  input  logic       evStop,
  input  logic       rdReq,
  output dpStrobe_t  strobe,
  output logic       serving,
  output logic       busy,
  output logic       donePulse,
  output logic       rejectPulse
);
  ctlState_t stateQ, stateD;
  logic cmdGood;
  logic doneQ, rejectQ;

  assign cmdGood = (cmdCode == CODE_BLKCALL && paramLo == 8'h01) ||
                   (cmdCode == CODE_VERSION);

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    strobe.mode = (cmdCode == CODE_VERSION) ? M_VERSION : M_COUNT;
    unique case (stateQ)
      S_IDLE: if (cmdValid && cmdGood) begin
        stateD = S_ARMED;
        strobe.load = 1'b1;
        strobe.clear = 1'b1;
      end
      S_ARMED: begin
        if (evRepStart) begin
          stateD = S_SERVE;
          strobe.clear = 1'b1;
        end else if (evStop) begin
          stateD = S_AFTERSTOP;
        end
      end
      S_AFTERSTOP: if (evStart || evRepStart) stateD = S_DEFAULT;
      S_SERVE: begin
        if (evStop) stateD = S_IDLE;
        else if (rdReq) strobe.advance = 1'b1;
      end
      S_DEFAULT: if (evStop) stateD = S_IDLE;
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= S_IDLE;
      doneQ   <= 1'b0;
      rejectQ <= 1'b0;
    end else begin
      stateQ  <= stateD;
      doneQ   <= evStop && (stateQ == S_SERVE || stateQ == S_DEFAULT);
      rejectQ <= cmdValid && (stateQ != S_IDLE || !cmdGood);
    end
  end

  assign serving     = (stateQ == S_SERVE);
  assign busy        = (stateQ != S_IDLE);
  assign donePulse   = doneQ;
  assign rejectPulse = rejectQ;

  // R3: unknown code in idle is refused and does not start a command
  a_r3_bad_code_rejected: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdValid && cmdCode != CODE_BLKCALL && cmdCode != CODE_VERSION)
      |=> (rejectPulse && !busy));

  // R9: a command during a live transfer is refused
  a_r9_busy_cmd_rejected: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdValid) |=> rejectPulse);

  // R8: done only follows a stop and leaves the block idle
  a_r8_done_after_stop: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> ($past(evStop) && !busy));
endmodule

// File: rtl/blkcall_dp.sv
module blkcall_dp
  import blkcall_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int VER_LEN = 6,
  parameter logic [8*VER_LEN-1:0] VER_STR = "v2.7.1"
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] countIn,
  output logic [7:0]       byteOut
);
  localparam int IDX_W = CNT_W + 1;

  respMode_t        modeQ;
  logic [CNT_W-1:0] countQ;
  logic [IDX_W-1:0] idxQ;
  logic [8*VER_LEN-1:0] verShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= M_COUNT;
      countQ <= '0;
      idxQ   <= '0;
    end else begin
      if (strobe.load) begin
        modeQ  <= strobe.mode;
        countQ <= countIn;
      end
      if (strobe.clear) idxQ <= '0;
      else if (strobe.advance && idxQ != '1) idxQ <= idxQ + 1'b1;
    end
  end

  always_comb begin
    verShift = '0;
    byteOut  = 8'h00;
    if (modeQ == M_COUNT) begin
      if (idxQ == '0)
        byteOut = 8'(countQ);
      else if (idxQ <= IDX_W'(countQ))
        byteOut = 8'(countQ - idxQ[CNT_W-1:0]);
    end else if (idxQ < IDX_W'(VER_LEN)) begin
      verShift = VER_STR >> (8 * (VER_LEN - 1 - int'(idxQ)));
      byteOut  = verShift[7:0];
    end
  end

  // R4: reply position only moves on control strobes
  a_r4_idx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clear && !strobe.advance) |=> $stable(idxQ));
endmodule

// File: rtl/blkcall_responder.sv
module blkcall_responder
  import blkcall_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int VER_LEN = 6,
  parameter logic [8*VER_LEN-1:0] VER_STR = "v2.7.1"
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [7:0] cmdCode,
  input  logic [7:0] paramLo,
  input  logic [7:0] paramHi,
  input  logic       evRepStart,
  input  logic       evStart,
  input  logic       evStop,
  input  logic       rdReq,
  output logic [7:0] rdData,
  output logic       repEntry,
  output logic       busy,
  output logic       donePulse,
  output logic       rejectPulse
);
  dpStrobe_t  strobe;
  logic       serving;
  logic [7:0] dpByte;

  blkcall_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .paramLo(paramLo), .evRepStart(evRepStart), .evStart(evStart),
    .evStop(evStop), .rdReq(rdReq), .strobe(strobe), .serving(serving),
    .busy(busy), .donePulse(donePulse), .rejectPulse(rejectPulse)
  );

  blkcall_dp #(.CNT_W(CNT_W), .VER_LEN(VER_LEN), .VER_STR(VER_STR)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .countIn(paramHi[CNT_W-1:0]), .byteOut(dpByte)
  );

  assign rdData   = serving ? dpByte : 8'h00;
  assign repEntry = serving;

  // R7: outside a repeated-start read only the default byte is offered
  a_r7_default_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !repEntry) |-> (rdData == 8'h00));

  // R10: serving a read implies a command is in progress
  a_r10_rep_implies_busy: assert property (@(posedge clk) disable iff (!rstN)
    repEntry |-> busy);
endmodule

// File: tb/blkcall_responder_bench.sv
`timescale 1ns/1ps
module blkcall_responder_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [7:0] cmdCode = '0, paramLo = '0, paramHi = '0;
  logic evRepStart = 1'b0, evStart = 1'b0, evStop = 1'b0, rdReq = 1'b0;
  logic [7:0] rdData;
  logic repEntry, busy, donePulse, rejectPulse;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  blkcall_responder u_blkcall_responder (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .paramLo(paramLo), .paramHi(paramHi), .evRepStart(evRepStart),
    .evStart(evStart), .evStop(evStop), .rdReq(rdReq), .rdData(rdData),
    .repEntry(repEntry), .busy(busy), .donePulse(donePulse),
    .rejectPulse(rejectPulse)
  );

  // {code, paramLo, paramHi, viaRepStart, readCount}
  localparam int NVEC = 6;
  localparam logic [39:0] VEC [NVEC] = '{
    {8'h03, 8'h01, 8'h10, 8'h01, 8'd19},
    {8'h03, 8'h01, 8'h00, 8'h01, 8'd3},
    {8'h04, 8'h00, 8'h00, 8'h01, 8'd9},
    {8'h04, 8'h00, 8'h00, 8'h00, 8'd3},
    {8'h03, 8'h01, 8'h05, 8'h00, 8'd2},
    {8'h03, 8'h01, 8'h03, 8'h01, 8'd6}
  };

  localparam logic [8*6-1:0] VERSION_TXT = "v2.7.1";

  function automatic logic [7:0] expByte(logic [7:0] code, logic [7:0] n,
                                         bit rep, int i);
    if (!rep) return 8'h00;                          // R7
    if (code == 8'h03) begin
      if (i == 0) return n;                          // R4
      if (i <= int'(n)) return 8'(int'(n) - i);      // R4
      return 8'h00;                                  // R5
    end
    if (i < 6) return VERSION_TXT[8*(5-i) +: 8];     // R6
    return 8'h00;                                    // R6 NUL and tail
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic sendCmd(logic [7:0] c, logic [7:0] lo, logic [7:0] hi);
    cmdCode = c; paramLo = lo; paramHi = hi; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic repStart();
    evRepStart = 1'b1; @(negedge clk); evRepStart = 1'b0;
  endtask

  task automatic stopStart();
    evStop = 1'b1; @(negedge clk); evStop = 1'b0;
    evStart = 1'b1; @(negedge clk); evStart = 1'b0;
  endtask

  task automatic readOne(string req, logic [7:0] exp);
    chk(req, rdData, exp);
    rdReq = 1'b1; @(negedge clk); rdReq = 1'b0;
  endtask

  task automatic endRead();
    evStop = 1'b1; @(negedge clk); evStop = 1'b0;
    chk("R8 done", 8'(donePulse), 8'h01);
    chk("R8 idle", 8'(busy), 8'h00);
    @(negedge clk);
    chk("R8 single pulse", 8'(donePulse), 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", 8'(busy), 8'h00);
    chk("R1 done", 8'(donePulse), 8'h00);
    chk("R1 reject", 8'(rejectPulse), 8'h00);
    chk("R1 repEntry", 8'(repEntry), 8'h00);
    chk("R1 rdData", rdData, 8'h00);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] c, lo, hi, cnt;
      bit rep;
      {c, lo, hi, cnt} = {VEC[v][39:16], VEC[v][7:0]};
      rep = VEC[v][8];
      sendCmd(c, lo, hi);
      chk("R2 accepted busy", 8'(busy), 8'h01);
      chk("R2 no reject", 8'(rejectPulse), 8'h00);
      if (rep) begin
        repStart();
        chk("R10 repEntry high", 8'(repEntry), 8'h01);
      end else begin
        stopStart();
        chk("R10 repEntry low", 8'(repEntry), 8'h00);
      end
      for (int i = 0; i < int'(cnt); i++)
        readOne(rep ? (c == 8'h04 ? "R6 version" : "R4/R5 countdown") : "R7 default",
                expByte(c, hi, rep, i));
      endRead();
    end

    // R2: wrong first parameter for block call
    sendCmd(8'h03, 8'h02, 8'h08);
    chk("R2 bad param reject", 8'(rejectPulse), 8'h01);
    chk("R2 bad param idle", 8'(busy), 8'h00);
    @(negedge clk);

    // R3: unknown codes
    sendCmd(8'h05, 8'h01, 8'h00);
    chk("R3 code 05 reject", 8'(rejectPulse), 8'h01);
    chk("R3 code 05 idle", 8'(busy), 8'h00);
    @(negedge clk);
    sendCmd(8'h00, 8'h01, 8'h00);
    chk("R3 code 00 reject", 8'(rejectPulse), 8'h01);
    chk("R3 code 00 idle", 8'(busy), 8'h00);
    @(negedge clk);

    // R9: new command during a live read
    sendCmd(8'h03, 8'h01, 8'h04);
    repStart();
    readOne("R9 first byte", 8'h04);
    readOne("R9 second byte", 8'h03);
    sendCmd(8'h03, 8'h01, 8'h07);
    chk("R9 reject while busy", 8'(rejectPulse), 8'h01);
    readOne("R9 continues", 8'h02);
    readOne("R9 continues", 8'h01);
    readOne("R9 continues", 8'h00);
    readOne("R5 tail", 8'h00);
    endRead();

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule